// File: doc/BRIEF.md
# Level Interrupt Controller with Latched Reset Switch

This block collects 32 interrupt request lines and presents them to a CPU through a single registered interrupt output. Software reaches it over a simple 32-bit register bus with byte enables. Three registers are decoded: a cause register at offset 0x00, a mask register at offset 0x04 and a platform-reset trigger at offset 0x24. A source is enabled by setting its mask bit. The CPU-visible pending set is the cause word ANDed with the mask word. The lowest-numbered pending source has priority.

Most cause bits are level-sensitive and simply follow their input lines. Cause bit 1 is the exception. It is fed by a reset-switch input (active low, `sw_n_i`). That input passes through a two-flop synchronizer, and the falling edge, which is a press, sets a sticky bit. The sticky bit remains set until software writes a 1 to bit 1 of the cause register. Cause bit 16 is a read-only copy of the synchronized switch level. It reads 1 while the switch is released and 0 while it is pressed.

Any write with at least one byte enabled to the reset-trigger offset produces a one-cycle platform reset pulse. This holds whatever data is written, including 0x00.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Cause bits other than bit 1 and bit 16 equal the corresponding `src_i` lines at all times. The `src_i` lines 1 and 16 have no effect on any output.
- R2: A read at offset 0x00 returns the cause word. Bit 1 is the sticky switch bit. Bit 16 is the synchronized switch level (1 = released, 0 = pressed). Every other bit is its source line. A read at any offset other than 0x00 and 0x04 returns 0.
- R3: The mask register at offset 0x04 is read/write. Each byte lane is written only when its byte enable (`bus_be_i[k]` for bits 8k+7..8k) is set. A mask bit of 1 enables its source.
- R4: A falling edge on `sw_n_i` sets cause bit 1 on the third rising clock edge after the change. The level flag in bit 16 drops on the second edge.
- R5: Cause bit 1 clears only when bit 1 is written as 1 to offset 0x00 with `bus_be_i[0]` set. Writing 0 to bit 1, or writing with `bus_be_i[0]` clear, leaves it set. A press edge in the same cycle as a clear wins.
- R6: `irq_o` is registered. It is 1 one clock after (cause AND mask, with bit 16 excluded) is nonzero, and 0 one clock after that value becomes zero.
- R7: Writing 0 to the mask register and then 0xFFFFFFFF to the cause register clears the sticky bit and leaves `irq_o` and `pend_vld_o` at 0.
- R8: Each write with a nonzero byte enable to offset 0x24 yields `plat_rst_o` = 1 for exactly the following clock cycle, whatever the data. A write with all byte enables clear yields no pulse.
- R9: `pend_vld_o` and `pend_idx_o` are registered with the same timing as `irq_o`. `pend_idx_o` is the index of the lowest-numbered pending bit.
- R10: After synchronous reset the mask is 0, the sticky bit is 0, and `irq_o`, `pend_vld_o` and `plat_rst_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level interrupt request lines, synchronous to clk |
| sw_n_i | input | 1 | Reset switch level, 0 = pressed, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Registered CPU interrupt request |
| pend_idx_o | output | 5 | Index of the lowest pending source |
| pend_vld_o | output | 1 | Some source is pending |
| plat_rst_o | output | 1 | One-cycle platform reset request |

## Verification
The bench builds the block with its defaults: 32 sources, an 8-bit offset, the switch at bit 1, its level flag at bit 16 and a two-stage synchronizer. These values put the full-width priority encoder within reach of the table, from index 0 up to index 31. They also make the exact three-edge press latency observable, and they let the byte-lane mask writes show partial updates across all four lanes.

// File: rtl/irqc_pkg.sv
// Shared register offsets of the level interrupt controller.
// Assumes byte addressing and 32-bit aligned registers.
package irqc_pkg;
    localparam int unsigned OFF_CAUSE = 32'h00;
    localparam int unsigned OFF_MASK  = 32'h04;
    localparam int unsigned OFF_PRST  = 32'h24;
endpackage

// File: rtl/irqc_sw_latch.sv
// Reset-switch front end: synchronizes the active-low switch level and
// latches a sticky flag on each press (falling) edge.
// Assumes sw_n_i is asynchronous; the synchronizer resets to "released"
// so that leaving reset never looks like a press.
module irqc_sw_latch #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_n_i,
    input  logic clr_i,
    output logic level_o,
    output logic latch_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sync_q;
    logic             press_w;
    logic             latch_q;

    // Purpose: shift the switch level through the synchronizer and an edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[DEPTH-2:0], sw_n_i};
    end

    assign level_o = sync_q[STAGES-1];
    assign press_w = sync_q[STAGES] & ~sync_q[STAGES-1];

    // Purpose: sticky press flag, a new press beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (press_w) latch_q <= 1'b1;
        else if (clr_i)   latch_q <= 1'b0;
    end

    assign latch_o = latch_q;

    AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        press_w |=> latch_o); // R4
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o && !clr_i) |=> latch_o); // R5
    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !press_w) |=> !latch_o); // R5
endmodule

// File: rtl/irqc_regs.sv
// Register bus decode: mask register with byte lanes, sticky-bit clear
// strobe, read mux and platform reset pulse.
// Assumes single-cycle accesses; read data is combinational.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8,
    parameter int SW_BIT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC/8-1:0] be_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] cause_rd_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               sw_clr_o,
    output logic               plat_rst_o
);
    localparam int NBYTE = NUM_SRC / 8;
    localparam int SW_LANE = SW_BIT / 8;

    logic               hit_cause, hit_mask, hit_prst;
    logic               wr_w;
    logic [NUM_SRC-1:0] mask_q, mask_d;
    logic               prst_q;

    assign hit_cause = (addr_i == ADDR_W'(OFF_CAUSE));
    assign hit_mask  = (addr_i == ADDR_W'(OFF_MASK));
    assign hit_prst  = (addr_i == ADDR_W'(OFF_PRST));
    assign wr_w      = sel_i && we_i;

    // Purpose: next mask value, one byte lane per enable.
    always_comb begin
        mask_d = mask_q;
        for (int b = 0; b < NBYTE; b++) begin
            if (wr_w && hit_mask && be_i[b]) mask_d[b*8 +: 8] = wdata_i[b*8 +: 8];
        end
    end

    // Purpose: mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Purpose: platform reset request, one cycle per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) prst_q <= 1'b0;
        else        prst_q <= wr_w && hit_prst && (|be_i);
    end

    // Purpose: read mux.
    always_comb begin
        rdata_o = '0;
        if (sel_i && !we_i) begin
            if (hit_cause)     rdata_o = cause_rd_i;
            else if (hit_mask) rdata_o = mask_q;
        end
    end

    assign sw_clr_o   = wr_w && hit_cause && be_i[SW_LANE] && wdata_i[SW_BIT];
    assign mask_o     = mask_q;
    assign plat_rst_o = prst_q;

    AST_MASK_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && we_i && addr_i == ADDR_W'(OFF_MASK) && (&be_i)) |=> (mask_o == $past(wdata_i))); // R3
    AST_PRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        plat_rst_o |-> $past(sel_i && we_i && addr_i == ADDR_W'(OFF_PRST) && (|be_i))); // R8
    AST_PRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (plat_rst_o && !(sel_i && we_i && addr_i == ADDR_W'(OFF_PRST))) |=> !plat_rst_o); // R8
endmodule

// File: rtl/irqc_pend.sv
// Cause assembly, pending computation, lowest-index priority encoder and
// registered CPU-side outputs.
// Assumes src_i is synchronous to clk; the level-flag bit never pends.
module irqc_pend #(
    parameter int NUM_SRC      = 32,
    parameter int SW_BIT       = 1,
    parameter int SW_STATE_BIT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic                       sw_latch_i,
    input  logic                       sw_level_i,
    input  logic [NUM_SRC-1:0]         mask_i,
    output logic [NUM_SRC-1:0]         cause_o,
    output logic                       irq_o,
    output logic [$clog2(NUM_SRC)-1:0] idx_o,
    output logic                       vld_o
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [NUM_SRC-1:0] NO_PEND = NUM_SRC'(1) << SW_STATE_BIT;

    logic [NUM_SRC-1:0] cause_w, pend_w;
    logic [IDX_W-1:0]   idx_w;
    logic               irq_q, vld_q;
    logic [IDX_W-1:0]   idx_q;

    // Purpose: merge level lines with the sticky bit and the level flag.
    always_comb begin
        cause_w               = src_i;
        cause_w[SW_BIT]       = sw_latch_i;
        cause_w[SW_STATE_BIT] = sw_level_i;
    end

    assign pend_w = cause_w & mask_i & ~NO_PEND;

    // Purpose: find the lowest-numbered pending bit.
    always_comb begin
        idx_w = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_w[i]) idx_w = IDX_W'(i);
        end
    end

    // Purpose: register the CPU-facing request and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vld_q <= 1'b0;
            idx_q <= '0;
        end else begin
            irq_q <= |pend_w;
            vld_q <= |pend_w;
            idx_q <= idx_w;
        end
    end

    assign cause_o = cause_w;
    assign irq_o   = irq_q;
    assign vld_o   = vld_q;
    assign idx_o   = idx_q;

    AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_i == '0) |-> (!irq_o && !vld_o)); // R7
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (($past(pend_w) & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0)); // R9
    AST_FLAG_NEVER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_o && idx_o == IDX_W'(SW_STATE_BIT))); // R6
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Top of the level interrupt controller: 32 level sources, one sticky
// reset-switch source, a read-only switch level flag, a mask register and
// a platform reset trigger on a simple register bus.
// Assumes NUM_SRC is a multiple of 8 and both special bits lie inside it.
module lvl_irq_ctrl #(
    parameter int NUM_SRC      = 32,
    parameter int ADDR_W       = 8,
    parameter int SW_BIT       = 1,
    parameter int SW_STATE_BIT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic                       sw_n_i,
    input  logic                       bus_sel_i,
    input  logic                       bus_we_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [NUM_SRC/8-1:0]       bus_be_i,
    input  logic [NUM_SRC-1:0]         bus_wdata_i,
    output logic [NUM_SRC-1:0]         bus_rdata_o,
    output logic                       irq_o,
    output logic [$clog2(NUM_SRC)-1:0] pend_idx_o,
    output logic                       pend_vld_o,
    output logic                       plat_rst_o
);
    logic               sw_clr, sw_level, sw_latch;
    logic [NUM_SRC-1:0] mask, cause;

    irqc_sw_latch #(.STAGES(SYNC_STAGES)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_n_i  (sw_n_i),
        .clr_i   (sw_clr),
        .level_o (sw_level),
        .latch_o (sw_latch)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SW_BIT(SW_BIT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel_i),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .be_i       (bus_be_i),
        .wdata_i    (bus_wdata_i),
        .cause_rd_i (cause),
        .rdata_o    (bus_rdata_o),
        .mask_o     (mask),
        .sw_clr_o   (sw_clr),
        .plat_rst_o (plat_rst_o)
    );

    irqc_pend #(.NUM_SRC(NUM_SRC), .SW_BIT(SW_BIT), .SW_STATE_BIT(SW_STATE_BIT)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .sw_latch_i (sw_latch),
        .sw_level_i (sw_level),
        .mask_i     (mask),
        .cause_o    (cause),
        .irq_o      (irq_o),
        .idx_o      (pend_idx_o),
        .vld_o      (pend_vld_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !pend_vld_o && !plat_rst_o)); // R10
endmodule

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sw_n = 1'b1;
    logic        sel = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, vld, prst;
    logic [4:0]  idx;
    int          n_chk = 0, n_err = 0;
    logic        done = 1'b0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    lvl_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .sw_n_i(sw_n),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq),
        .pend_idx_o(idx), .pend_vld_o(vld), .plat_rst_o(prst)
    );

    localparam int NV = 7;
    localparam logic [31:0] V_SRC  [NV] = '{32'h0000_0000, 32'h0000_0100, 32'h8000_0010,
                                             32'h0001_0002, 32'hFFFF_FFFF, 32'h0000_0001, 32'h00F0_0000};
    localparam logic [31:0] V_MASK [NV] = '{32'hFFFF_FFFF, 32'h0000_0100, 32'h8000_0000,
                                             32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h0000_0001, 32'h00C0_0000};
    localparam logic [4:0]  V_IDX  [NV] = '{5'd0, 5'd8, 5'd31, 5'd0, 5'd4, 5'd0, 5'd22};
    localparam logic        V_VLD  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; we = 1'b0; be = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 irq", {31'd0, irq}, 32'd0);
        chk("R10 vld", {31'd0, vld}, 32'd0);
        chk("R10 plat_rst", {31'd0, prst}, 32'd0);
        bus_rd(8'h04, rv); chk("R10 mask", rv, 32'd0);
        bus_rd(8'h00, rv); chk("R10 R2 cause", rv, 32'h0001_0000);
        bus_rd(8'h10, rv); chk("R2 unmapped read", rv, 32'd0);

        // table walk: R1 R6 R9
        for (int k = 0; k < NV; k++) begin
            bus_wr(8'h04, V_MASK[k], 4'hF);
            src = V_SRC[k];
            step();
            chk("R6 irq", {31'd0, irq}, {31'd0, V_VLD[k]});
            chk("R9 vld", {31'd0, vld}, {31'd0, V_VLD[k]});
            if (V_VLD[k]) chk("R9 idx", {27'd0, idx}, {27'd0, V_IDX[k]});
        end

        // R1 R2 cause readback, ignored lines 1 and 16
        src = 32'hFFFE_FFFF;
        bus_rd(8'h00, rv); chk("R1 cause", rv, 32'hFFFF_FFFD);

        // R3 byte lanes
        bus_wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h04, 32'h1234_5678, 4'b0101);
        bus_rd(8'h04, rv); chk("R3 mask lanes", rv, 32'hFF34_FF78);

        // R4 press latency
        src = '0;
        bus_wr(8'h04, 32'h0000_0002, 4'hF);
        sw_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_rd(8'h00, rv); chk("R4 two edges", rv, 32'h0000_0000);
        step();
        bus_rd(8'h00, rv); chk("R4 three edges", rv, 32'h0000_0002);
        step();
        chk("R6 switch irq", {31'd0, irq}, 32'd1);
        chk("R9 switch idx", {27'd0, idx}, 32'd1);

        // R5 sticky clear rules
        sw_n = 1'b1;
        repeat (4) step();
        bus_rd(8'h00, rv); chk("R5 held after release", rv, 32'h0001_0002);
        bus_wr(8'h00, 32'hFFFF_FFFD, 4'hF);
        bus_rd(8'h00, rv); chk("R5 write zero", rv, 32'h0001_0002);
        bus_wr(8'h00, 32'h0000_0002, 4'b1110);
        bus_rd(8'h00, rv); chk("R5 lane disabled", rv, 32'h0001_0002);
        chk("R8 no pulse on cause write", {31'd0, prst}, 32'd0);
        bus_wr(8'h00, 32'h0000_0002, 4'b0001);
        bus_rd(8'h00, rv); chk("R5 cleared", rv, 32'h0001_0000);
        step();
        chk("R6 irq drops", {31'd0, irq}, 32'd0);

        // R7 quiesce
        src = 32'hFFFF_FFFF;
        bus_wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        sw_n = 1'b0;
        repeat (5) step();
        chk("R7 busy before", {31'd0, irq}, 32'd1);
        bus_wr(8'h04, 32'h0000_0000, 4'hF);
        bus_wr(8'h00, 32'hFFFF_FFFF, 4'hF);
        step();
        chk("R7 irq", {31'd0, irq}, 32'd0);
        chk("R7 vld", {31'd0, vld}, 32'd0);
        bus_rd(8'h00, rv); chk("R7 cause", rv, 32'hFFFE_FFFD);

        // R8 reset trigger
        bus_wr(8'h24, 32'h0000_0000, 4'b0001);
        chk("R8 pulse", {31'd0, prst}, 32'd1);
        step();
        chk("R8 pulse ends", {31'd0, prst}, 32'd0);
        bus_wr(8'h24, 32'hFFFF_FFFF, 4'b0000);
        chk("R8 no enables", {31'd0, prst}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule